// File: doc/BRIEF.md
# Coarse Shading Rate Selector

This block picks the coarse shading rate for each pixel handed to it by the rasterizer and marks which pixels begin a new pixel-shader invocation. For every pixel it combines three rate sources: a rate fixed for the whole draw, a rate that arrives with the current triangle, and a rate read from a screen-space rate image. Each image entry covers one 8x8 pixel tile.

When a pixel arrives, the block puts out that pixel's tile index on a lookup port. The image store answers one cycle later. The pixel's other inputs are held in a register stage for that cycle, so each result leaves aligned with its own image answer. The block outputs the final rate code and the coarse-pixel anchor coordinate. It also outputs a flag that is set on the pixel that starts a new invocation. The rate image itself, rasterization and shading sit outside the block.

Top module: `vrs_rate_select`

## Requirements
- R1: Rate codes are 3 bits, written as width x height: 1x1=000, 1x2=001, 2x1=100, 2x2=101, 2x4=110, 4x2=111, 4x4=011. The unused code 010 is read as 1x1 on every input, and the output never carries 010.
- R2: In the same cycle as `px_valid`, `img_req` is high and `img_tile_x`/`img_tile_y` equal the pixel coordinates shifted right by 3.
- R3: `img_rate` is sampled in the cycle after the request. `out_valid` and all results for a pixel appear exactly one cycle after that pixel's input cycle.
- R4: The final rate takes, separately for width and for height, the largest of the draw, triangle and image rates.
- R5: Combining a 2x4 source with a 4x2 source gives 4x4, whichever sources carry them.
- R6: The anchor is the pixel coordinate with its low log2(width) bits of x and its low log2(height) bits of y cleared.
- R7: `out_new_inv` is high exactly when `out_valid` is high and the pixel equals its anchor.
- R8: While reset is asserted and right after it, `out_valid`, `out_new_inv` and `img_req` are low.
- R9: In a cycle after an input cycle with `px_valid` low, `out_valid` and `out_new_inv` are low.
- R10: Over one 8x8 tile at a single rate, 4x4 raises `out_new_inv` 4 times and 2x2 raises it 16 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_valid | input | 1 | A pixel is presented this cycle |
| px_x | input | XW | Pixel x coordinate |
| px_y | input | YW | Pixel y coordinate |
| draw_rate | input | 3 | Rate set for the current draw |
| prim_rate | input | 3 | Rate carried by the current triangle |
| img_req | output | 1 | Rate image lookup request |
| img_tile_x | output | XW-3 | Tile column to look up |
| img_tile_y | output | YW-3 | Tile row to look up |
| img_rate | input | 3 | Rate image answer, one cycle after the request |
| out_valid | output | 1 | Result valid |
| out_rate | output | 3 | Final combined rate code |
| out_anchor_x | output | XW | Coarse-pixel anchor x |
| out_anchor_y | output | YW | Coarse-pixel anchor y |
| out_new_inv | output | 1 | Pixel starts a new invocation |

## Verification
The tile lookup is combinational, so the bench samples it 1 ns after it drives a pixel at a falling edge, in the same cycle as the pixel. Every other result depends on one register stage plus the image answer. The bench samples those at the next falling edge, one full cycle after the drive, and checks at that point that `out_valid` was still low before the edge. The image model in the bench answers on the rising edge, as a real store would, so the output only matches if the one-cycle alignment holds. The tile sweep brings in one pixel per two cycles and counts the flags at the same delayed sample point.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef logic [2:0] rate_code_t;

  typedef struct packed {
    logic [1:0] lw;  // log2 coarse width
    logic [1:0] lh;  // log2 coarse height
  } rate_log_t;

  function automatic rate_log_t rate_decode(input rate_code_t c);
    rate_log_t r;
    case (c)
      3'b001:  r = '{lw: 2'd0, lh: 2'd1};
      3'b100:  r = '{lw: 2'd1, lh: 2'd0};
      3'b101:  r = '{lw: 2'd1, lh: 2'd1};
      3'b110:  r = '{lw: 2'd1, lh: 2'd2};
      3'b111:  r = '{lw: 2'd2, lh: 2'd1};
      3'b011:  r = '{lw: 2'd2, lh: 2'd2};
      default: r = '{lw: 2'd0, lh: 2'd0};  // 000 and reserved 010
    endcase
    return r;
  endfunction

  // Unsupported pairs fall back to the nearest finer legal rate.
  function automatic rate_code_t rate_encode(input rate_log_t r);
    rate_code_t c;
    case ({r.lw, r.lh})
      4'b00_01, 4'b00_10: c = 3'b001;
      4'b01_00, 4'b10_00: c = 3'b100;
      4'b01_01:           c = 3'b101;
      4'b01_10:           c = 3'b110;
      4'b10_01:           c = 3'b111;
      4'b10_10:           c = 3'b011;
      default:            c = 3'b000;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/vrs_tile_addr.sv
module vrs_tile_addr #(
  parameter int XW = 14,
  parameter int YW = 14,
  parameter int TILE_LOG2 = 3,
  localparam int TXW = XW - TILE_LOG2,
  localparam int TYW = YW - TILE_LOG2
) (
  input  logic          valid,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic          req,
  output logic [TXW-1:0] tile_x,
  output logic [TYW-1:0] tile_y
);
  assign req    = valid;
  assign tile_x = x[XW-1:TILE_LOG2];
  assign tile_y = y[YW-1:TILE_LOG2];
endmodule

// File: rtl/vrs_rate_combine.sv
module vrs_rate_combine
  import vrs_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][2:0] src_rate,
  output logic [2:0]           rate
);
  rate_log_t dec [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    assign dec[g] = rate_decode(src_rate[g]);
  end

  rate_log_t acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (dec[i].lw > acc.lw) acc.lw = dec[i].lw;
      if (dec[i].lh > acc.lh) acc.lh = dec[i].lh;
    end
  end

  assign rate = rate_encode(acc);
endmodule

// File: rtl/vrs_anchor.sv
module vrs_anchor
  import vrs_pkg::*;
#(
  parameter int XW = 14,
  parameter int YW = 14
) (
  input  logic          valid,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [2:0]    rate,
  output logic [XW-1:0] anchor_x,
  output logic [YW-1:0] anchor_y,
  output logic          new_inv
);
  rate_log_t r;
  logic [XW-1:0] mask_x;
  logic [YW-1:0] mask_y;

  always_comb begin
    r        = rate_decode(rate);
    mask_x   = {XW{1'b1}} << r.lw;
    mask_y   = {YW{1'b1}} << r.lh;
    anchor_x = x & mask_x;
    anchor_y = y & mask_y;
    new_inv  = valid && (anchor_x == x) && (anchor_y == y);
  end
endmodule

// File: rtl/vrs_rate_select.sv
module vrs_rate_select #(
  parameter int XW = 14,
  parameter int YW = 14,
  localparam int TILE_LOG2 = 3,
  localparam int TXW = XW - TILE_LOG2,
  localparam int TYW = YW - TILE_LOG2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           px_valid,
  input  logic [XW-1:0]  px_x,
  input  logic [YW-1:0]  px_y,
  input  logic [2:0]     draw_rate,
  input  logic [2:0]     prim_rate,
  output logic           img_req,
  output logic [TXW-1:0] img_tile_x,
  output logic [TYW-1:0] img_tile_y,
  input  logic [2:0]     img_rate,
  output logic           out_valid,
  output logic [2:0]     out_rate,
  output logic [XW-1:0]  out_anchor_x,
  output logic [YW-1:0]  out_anchor_y,
  output logic           out_new_inv
);
  vrs_tile_addr #(.XW(XW), .YW(YW), .TILE_LOG2(TILE_LOG2)) u_tile (
    .valid(px_valid), .x(px_x), .y(px_y),
    .req(img_req), .tile_x(img_tile_x), .tile_y(img_tile_y)
  );

  // Stage holding the pixel while the image lookup is in flight.
  logic          st_valid_q, st_valid_d;
  logic [XW-1:0] st_x_q, st_x_d;
  logic [YW-1:0] st_y_q, st_y_d;
  logic [2:0]    st_draw_q, st_draw_d;
  logic [2:0]    st_prim_q, st_prim_d;
  logic          st_en;

  always_comb begin
    st_en      = px_valid;
    st_valid_d = px_valid;
    st_x_d     = px_x;
    st_y_d     = px_y;
    st_draw_d  = draw_rate;
    st_prim_d  = prim_rate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_valid_q <= 1'b0;
    else        st_valid_q <= st_valid_d;
  end

  always_ff @(posedge clk) begin
    if (st_en) begin
      st_x_q    <= st_x_d;
      st_y_q    <= st_y_d;
      st_draw_q <= st_draw_d;
      st_prim_q <= st_prim_d;
    end
  end

  vrs_rate_combine #(.NSRC(3)) u_comb (
    .src_rate({img_rate, st_prim_q, st_draw_q}),
    .rate(out_rate)
  );

  vrs_anchor #(.XW(XW), .YW(YW)) u_anchor (
    .valid(st_valid_q), .x(st_x_q), .y(st_y_q), .rate(out_rate),
    .anchor_x(out_anchor_x), .anchor_y(out_anchor_y), .new_inv(out_new_inv)
  );

  assign out_valid = st_valid_q;
endmodule

// File: rtl/vrs_rate_select_chk.sv
module vrs_rate_select_chk #(
  parameter int XW = 14,
  parameter int YW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          px_valid,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic [2:0]    draw_rate,
  input logic          out_valid,
  input logic [2:0]    out_rate,
  input logic [XW-1:0] out_anchor_x,
  input logic [YW-1:0] out_anchor_y,
  input logic          out_new_inv
);
  assert_valid_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> out_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |=> !out_valid && !out_new_inv);

  assert_rate_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_rate != 3'b010);

  assert_draw_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && draw_rate == 3'b011 |=> out_rate == 3'b011);

  assert_anchor_le_R6: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> out_anchor_x <= $past(px_x) && out_anchor_y <= $past(px_y));

  assert_newinv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> (out_new_inv == (out_anchor_x == $past(px_x) && out_anchor_y == $past(px_y))));
endmodule

bind vrs_rate_select vrs_rate_select_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
  .draw_rate(draw_rate), .out_valid(out_valid), .out_rate(out_rate),
  .out_anchor_x(out_anchor_x), .out_anchor_y(out_anchor_y),
  .out_new_inv(out_new_inv)
);

// File: tb/vrs_rate_select_tb.sv
module vrs_rate_select_tb;
  localparam int XW = 14;
  localparam int YW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic px_valid = 1'b0;
  logic [XW-1:0] px_x = '0;
  logic [YW-1:0] px_y = '0;
  logic [2:0] draw_rate = '0, prim_rate = '0, img_rate;
  logic img_req, out_valid, out_new_inv;
  logic [XW-4:0] img_tile_x;
  logic [YW-4:0] img_tile_y;
  logic [2:0] out_rate;
  logic [XW-1:0] out_anchor_x;
  logic [YW-1:0] out_anchor_y;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  vrs_rate_select #(.XW(XW), .YW(YW)) u_dut (.*);

  // Rate image model: one cycle of read latency.
  function automatic logic [2:0] img_map(input int tx, input int ty);
    case ((tx + 2 * ty) % 8)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b100; 3: return 3'b101;
      4: return 3'b110; 5: return 3'b111; 6: return 3'b011; default: return 3'b010;
    endcase
  endfunction

  always_ff @(posedge clk) img_rate <= img_map(int'(img_tile_x), int'(img_tile_y));

  // Reference model taken from the requirements.
  function automatic int lw_of(input logic [2:0] c);
    case (c) 3'b100, 3'b101, 3'b110: return 1; 3'b111, 3'b011: return 2; default: return 0; endcase
  endfunction
  function automatic int lh_of(input logic [2:0] c);
    case (c) 3'b001, 3'b101, 3'b111: return 1; 3'b110, 3'b011: return 2; default: return 0; endcase
  endfunction
  function automatic logic [2:0] code_of(input int w, input int h);
    case (w * 3 + h)
      0: return 3'b000; 1, 2: return 3'b001; 3, 6: return 3'b100; 4: return 3'b101;
      5: return 3'b110; 7: return 3'b111; default: return 3'b011;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One pixel: drive at a falling edge, check the lookup at once, results one cycle later.
  task automatic pixel(input int x, input int y, input logic [2:0] d, input logic [2:0] p,
                       input string req);
    int w, h, ax, ay;
    logic [2:0] im, exp_rate;
    @(negedge clk);
    px_valid = 1'b1; px_x = XW'(x); px_y = YW'(y); draw_rate = d; prim_rate = p;
    #1;
    check({req, " R2 req"}, img_req, 1);
    check({req, " R2 tile_x"}, img_tile_x, x >> 3);
    check({req, " R2 tile_y"}, img_tile_y, y >> 3);
    check({req, " R3 not early"}, out_valid, 0);
    im = img_map(x >> 3, y >> 3);
    w = lw_of(d); if (lw_of(p) > w) w = lw_of(p); if (lw_of(im) > w) w = lw_of(im);
    h = lh_of(d); if (lh_of(p) > h) h = lh_of(p); if (lh_of(im) > h) h = lh_of(im);
    exp_rate = code_of(w, h);
    ax = (x >> w) << w; ay = (y >> h) << h;
    @(negedge clk);
    px_valid = 1'b0;
    check({req, " R3 valid"}, out_valid, 1);
    check({req, " R4 rate"}, out_rate, exp_rate);
    check({req, " R6 ax"}, out_anchor_x, ax);
    check({req, " R6 ay"}, out_anchor_y, ay);
    check({req, " R7 flag"}, out_new_inv, (ax == x && ay == y));
  endtask

  task automatic t_reset;
    #1;
    check("R8 valid in reset", out_valid, 0);
    check("R8 flag in reset", out_new_inv, 0);
    check("R8 req in reset", img_req, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid after reset", out_valid, 0);
  endtask

  task automatic t_combine;
    pixel(100, 37, 3'b000, 3'b000, "R4 image only");   // tile 12,4 -> 110
    pixel(5, 3, 3'b101, 3'b000, "R4 draw 2x2");
    pixel(13, 2, 3'b001, 3'b100, "R4 mixed axes");     // tile 1,0 image 1x2
    pixel(22, 9, 3'b000, 3'b111, "R4 prim 4x2");
    pixel(1000, 777, 3'b110, 3'b001, "R6 high coords");
  endtask

  task automatic t_reserved;
    pixel(3, 5, 3'b010, 3'b010, "R1 reserved inputs");   // image 000 -> 1x1
    check("R1 reserved out", out_rate, 3'b000);
    pixel(57, 1, 3'b010, 3'b000, "R1 reserved image");   // tile 7,0 -> 010
    check("R1 reserved img out", out_rate, 3'b000);
  endtask

  task automatic t_cross;
    pixel(2, 6, 3'b110, 3'b111, "R5 2x4 with 4x2");
    check("R5 result 4x4", out_rate, 3'b011);
    pixel(2, 6, 3'b111, 3'b110, "R5 swapped sources");
    check("R5 swapped 4x4", out_rate, 3'b011);
  endtask

  task automatic t_bubble;
    pixel(4, 4, 3'b000, 3'b000, "R9 before bubble");
    @(negedge clk);
    check("R9 valid idle", out_valid, 0);
    check("R9 flag idle", out_new_inv, 0);
  endtask

  task automatic sweep(input logic [2:0] d, input int exp_cnt, input string req);
    int cnt = 0;
    for (int yy = 0; yy < 8; yy++) begin
      for (int xx = 0; xx < 8; xx++) begin
        @(negedge clk);
        px_valid = 1'b1; px_x = XW'(xx); px_y = YW'(yy); draw_rate = d; prim_rate = 3'b000;
        @(negedge clk);
        px_valid = 1'b0;
        if (out_new_inv) cnt++;
      end
    end
    check(req, cnt, exp_cnt);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_combine;
        t_reserved;
        t_cross;
        t_bubble;
        sweep(3'b011, 4, "R10 4x4 count");
        sweep(3'b101, 16, "R10 2x2 count");
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule